// File: doc/BRIEF.md
# Soft Key Crossfade Switch

This block picks the sample that drives a composite video output. It chooses between the stream that the encoder builds internally from luma and chroma and a composite sample bus supplied from outside. A one-bit key that travels with the pixels selects the source. The key is captured on the pixel clock in the same way as the pixel data. A change of key does not cause a hard cut. Instead the block blends the two sources over four pixel clocks, which keeps out-of-band energy low. The luma and chroma outputs are never switched and are not part of this block.

Both sample streams and the key pass through pipelines of matched length. The middle of each blend therefore falls on the output pixel that entered together with the key edge. The blend covers the two pixels before that point and the two pixels from it onward. An advance input shifts the key five pixel clocks earlier relative to the data. The weighting is held as a small level counter that moves by one step per clock towards the key. When the key flips partway through a blend, the blend turns back from the weight it has reached and never jumps.

Top module: `soft_key_xfade`

## Requirements
- R1: While reset is asserted the output reads 0. After reset the weight fully selects the internal stream, so a constant internal sample appears unchanged at the output once the pipeline has filled.
- R2: With the key low long enough, the output for each pixel equals that pixel's internal sample. It appears after the ninth rising clock edge following the edge that captured the pixel.
- R3: With the key high long enough, the output for each pixel equals that pixel's external sample, with the same latency as R2.
- R4: Let the key rise on pixel t with advance low. Pixels t-2, t-1, t and t+1 then receive the external source at weights 1/8, 3/8, 5/8 and 7/8, and pixel t+2 onward receives it at 8/8.
- R5: Let the key fall on pixel t with advance low. Pixels t-2 through t+1 then receive the external source at weights 7/8, 5/8, 3/8 and 1/8, and pixel t+2 onward receives it at 0.
- R6: With advance high, the same weight sequences fall on pixels t-7 through t-4. The key acts five pixel clocks earlier.
- R7: A key that reverses mid-blend moves the weight back one step per pixel from where it stands. A key high for exactly pixels t and t+1, with the key low before and after, gives weights 1/8, 3/8, 1/8 and 0 on pixels t-2 to t+1.
- R8: Each output equals floor((int*(8-w) + ext*w + 4) / 8), where w is the external weight in eighths. The result is limited to 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| adv_i | input | 1 | 1 = key takes effect five pixel clocks earlier |
| key_i | input | 1 | Source key captured with each pixel, 1 = external bus |
| enc_i | input | DW (10) | Internally encoded composite sample |
| ext_i | input | DW (10) | External composite sample bus |
| mix_o | output | DW (10) | Blended composite output sample |

## Verification
A pixel driven before rising edge n is on the output after rising edge n+9. The bench drives one pixel at each falling edge and reads the output at the falling edge ten iterations later. That read is half a clock after the output register updates. The key's weight applies to the pixel two positions before the key with advance low, and seven positions before it with advance high. The bench's level model therefore writes each weight into the slot of the pixel it lands on, and each captured output is compared against that slot. The reset check waits fourteen clocks after release so that the two-flop synchronizer and the ten-stage path have both settled.

// File: rtl/sk_xfade_pkg.sv
package sk_xfade_pkg;
  // number of blended pixels per key transition
  localparam int unsigned XF_STEPS = 4;
  // level 0 = internal only, LVL_MAX = external only
  localparam int unsigned LVL_MAX  = XF_STEPS + 1;
  localparam int unsigned LVL_W    = $clog2(LVL_MAX + 1);
  // weights are counted in units of 1/WT_FULL
  localparam int unsigned WT_FULL  = 2 * XF_STEPS;
  localparam int unsigned WT_SHIFT = $clog2(WT_FULL);
  localparam int unsigned WT_W     = WT_SHIFT + 1;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [WT_W-1:0]  wt_t;

  typedef enum logic [1:0] {
    LV_HOLD,
    LV_UP,
    LV_DOWN
  } lv_move_e;

  // odd-eighths ladder: 0, 1, 3, 5, 7, 8 for four steps
  function automatic wt_t lvl_to_wt(input lvl_t lvl);
    if (lvl == '0) begin
      return '0;
    end else if (int'(lvl) >= int'(LVL_MAX)) begin
      return wt_t'(WT_FULL);
    end else begin
      return wt_t'(2 * int'(lvl) - 1);
    end
  endfunction
endpackage

// File: rtl/sk_delay_line.sv
module sk_delay_line #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [DEPTH-1:0][WIDTH-1:0] stg_q;
  logic [DEPTH-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d[0] = d_i;
    for (int i = 1; i < int'(DEPTH); i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/sk_blend_ctrl.sv
module sk_blend_ctrl
  import sk_xfade_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tgt_i,
  output lvl_t lvl_o,
  output wt_t  wt_o
);
  lvl_t     lvl_q;
  lvl_t     lvl_d;
  lv_move_e move;

  always_comb begin
    move = LV_HOLD;
    if (tgt_i && (int'(lvl_q) < int'(LVL_MAX))) begin
      move = LV_UP;
    end else if (!tgt_i && (lvl_q != '0)) begin
      move = LV_DOWN;
    end
    case (move)
      LV_UP:   lvl_d = lvl_q + lvl_t'(1);
      LV_DOWN: lvl_d = lvl_q - lvl_t'(1);
      default: lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else begin
      lvl_q <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;
  assign wt_o  = lvl_to_wt(lvl_q);
endmodule

// File: rtl/sk_mixer.sv
module sk_mixer
  import sk_xfade_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] enc_i,
  input  logic [DW-1:0] ext_i,
  input  wt_t           wt_i,
  output logic [DW-1:0] mix_o
);
  localparam int unsigned ACC_W = DW + WT_W + 1;
  localparam logic [ACC_W-1:0] RND_ADD = ACC_W'(WT_FULL / 2);
  localparam logic [ACC_W-1:0] SAT_TOP = {{(ACC_W-DW){1'b0}}, {DW{1'b1}}};

  wt_t              inv_wt;
  logic [ACC_W-1:0] enc_term;
  logic [ACC_W-1:0] ext_term;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] scaled;
  logic [DW-1:0]    mix_d;
  logic [DW-1:0]    mix_q;

  always_comb begin
    inv_wt   = wt_t'(WT_FULL) - wt_i;
    enc_term = ACC_W'(enc_i) * ACC_W'(inv_wt);
    ext_term = ACC_W'(ext_i) * ACC_W'(wt_i);
    acc      = enc_term + ext_term + RND_ADD;
    scaled   = acc >> WT_SHIFT;
    mix_d    = (scaled > SAT_TOP) ? {DW{1'b1}} : scaled[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mix_q <= '0;
    end else begin
      mix_q <= mix_d;
    end
  end

  assign mix_o = mix_q;
endmodule

// File: rtl/soft_key_xfade.sv
module soft_key_xfade
  import sk_xfade_pkg::*;
#(
  parameter int unsigned DW      = 10,
  parameter int unsigned ADV_CYC = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          key_i,
  input  logic [DW-1:0] enc_i,
  input  logic [DW-1:0] ext_i,
  output logic [DW-1:0] mix_o
);
  // data waits for the key to lead it by half a blend plus the advance
  localparam int unsigned DATA_DEPTH = ADV_CYC + XF_STEPS / 2 + 2;
  localparam int unsigned PAIR_W     = 2 * DW;

  logic rst_meta;
  logic rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  // key capture, registered like a pixel bit
  logic key_q;
  logic key_sel;

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      key_q <= 1'b0;
    end else begin
      key_q <= key_i;
    end
  end

  if (ADV_CYC == 0) begin : g_no_adv
    assign key_sel = key_q;
  end else begin : g_adv
    logic key_late;
    sk_delay_line #(
      .WIDTH (1),
      .DEPTH (ADV_CYC)
    ) key_dly_i (
      .clk   (clk),
      .rst_n (rst_sync),
      .d_i   (key_q),
      .q_o   (key_late)
    );
    assign key_sel = adv_i ? key_q : key_late;
  end

  // matched pipe for both sample streams
  logic [PAIR_W-1:0] pair_in;
  logic [PAIR_W-1:0] pair_tap;
  logic [DW-1:0]     enc_tap;
  logic [DW-1:0]     ext_tap;

  assign pair_in = {enc_i, ext_i};

  sk_delay_line #(
    .WIDTH (PAIR_W),
    .DEPTH (DATA_DEPTH)
  ) data_dly_i (
    .clk   (clk),
    .rst_n (rst_sync),
    .d_i   (pair_in),
    .q_o   (pair_tap)
  );

  assign enc_tap = pair_tap[PAIR_W-1:DW];
  assign ext_tap = pair_tap[DW-1:0];

  lvl_t lvl;
  wt_t  wt;

  sk_blend_ctrl blend_i (
    .clk   (clk),
    .rst_n (rst_sync),
    .tgt_i (key_sel),
    .lvl_o (lvl),
    .wt_o  (wt)
  );

  sk_mixer #(
    .DW (DW)
  ) mixer_i (
    .clk   (clk),
    .rst_n (rst_sync),
    .enc_i (enc_tap),
    .ext_i (ext_tap),
    .wt_i  (wt),
    .mix_o (mix_o)
  );
endmodule

// File: rtl/sk_xfade_chk.sv
module sk_xfade_chk
  import sk_xfade_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          key_sel,
  input lvl_t          lvl,
  input logic [DW-1:0] enc_tap,
  input logic [DW-1:0] ext_tap,
  input logic [DW-1:0] mix_o
);
  // R7
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lvl) <= int'(LVL_MAX));

  // R7
  lvl_no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lvl == $past(lvl)) || (lvl == $past(lvl) + lvl_t'(1)) ||
              (lvl == $past(lvl) - lvl_t'(1))));

  // R4
  lvl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_sel && (int'(lvl) < int'(LVL_MAX))) |=> (lvl == $past(lvl) + lvl_t'(1)));

  // R5
  lvl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_sel && (lvl != '0)) |=> (lvl == $past(lvl) - lvl_t'(1)));

  // R2
  int_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == '0) |=> (mix_o == $past(enc_tap)));

  // R3
  ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lvl) == int'(LVL_MAX)) |=> (mix_o == $past(ext_tap)));
endmodule

bind soft_key_xfade sk_xfade_chk #(
  .DW (DW)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_sync),
  .key_sel (key_sel),
  .lvl     (lvl),
  .enc_tap (enc_tap),
  .ext_tap (ext_tap),
  .mix_o   (mix_o)
);

// File: tb/soft_key_xfade_tb_top.sv
module soft_key_xfade_tb_top;
  localparam int DW  = 10;
  localparam int N   = 64;
  localparam int LEN = 80;
  localparam int LAT = 10;

  logic          clk;
  logic          rst_n;
  logic          adv_i;
  logic          key_i;
  logic [DW-1:0] enc_i;
  logic [DW-1:0] ext_i;
  logic [DW-1:0] mix_o;

  int n_chk;
  int n_fail;

  logic [DW-1:0] enc_a [LEN];
  logic [DW-1:0] ext_a [LEN];
  logic          key_a [LEN];
  int            wexp  [N];
  int            got_a [N];
  logic [15:0]   lfsr;

  soft_key_xfade dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (adv_i),
    .key_i (key_i),
    .enc_i (enc_i),
    .ext_i (ext_i),
    .mix_o (mix_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic int lvl_wt(input int l);
    if (l == 0) return 0;
    if (l >= 5) return 8;
    return 2 * l - 1;
  endfunction

  // R1: reset clears output and leaves the internal stream selected
  task automatic do_reset();
    rst_n = 1'b0;
    key_i = 1'b0;
    enc_i = 10'd300;
    ext_i = 10'd900;
    repeat (4) @(negedge clk);
    check("R1 reset output", int'(mix_o), 0);
    rst_n = 1'b1;
    repeat (14) @(negedge clk);
    check("R1 internal after reset", int'(mix_o), 300);
  endtask

  task automatic fill_const(input int e, input int x);
    for (int i = 0; i < LEN; i++) begin
      enc_a[i] = DW'(e);
      ext_a[i] = DW'(x);
      key_a[i] = 1'b0;
    end
  endtask

  task automatic set_key(input int from, input int to);
    for (int i = from; i < to; i++) key_a[i] = 1'b1;
  endtask

  task automatic fill_rand();
    for (int i = 0; i < LEN; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      enc_a[i] = lfsr[9:0];
      ext_a[i] = {lfsr[3:0], lfsr[15:10]};
      key_a[i] = (i > 4) && (lfsr[11] ^ lfsr[2]) && lfsr[7];
    end
  endtask

  task automatic build_model(input bit adv);
    int lead;
    int lv;
    lead = adv ? 7 : 2;
    lv = 0;
    for (int q = 0; q < LEN; q++) begin
      if (key_a[q]) lv = (lv < 5) ? lv + 1 : 5;
      else          lv = (lv > 0) ? lv - 1 : 0;
      if ((q - lead >= 0) && (q - lead < N)) wexp[q - lead] = lvl_wt(lv);
    end
  endtask

  task automatic run_stream(input bit adv);
    adv_i = adv;
    for (int m = 0; m < N + LAT; m++) begin
      @(negedge clk);
      if (m >= LAT) got_a[m - LAT] = int'(mix_o);
      enc_i = enc_a[m];
      ext_i = ext_a[m];
      key_i = key_a[m];
    end
    build_model(adv);
    for (int p = 0; p < N; p++) begin
      int w;
      int ex;
      w  = wexp[p];
      ex = (int'(enc_a[p]) * (8 - w) + int'(ext_a[p]) * w + 4) / 8;
      if (ex > 1023) ex = 1023;
      if (w == 0)      check("R2 internal pass", got_a[p], ex);
      else if (w == 8) check("R3 external pass", got_a[p], ex);
      else             check("R8 blended sample", got_a[p], ex);
    end
    key_i = 1'b0;
  endtask

  initial begin
    n_chk  = 0;
    n_fail = 0;
    lfsr   = 16'hACE1;
    adv_i  = 1'b0;
    do_reset();

    // key rise at 10, fall at 22, two-pixel pulse at 40
    fill_const(0, 800);
    set_key(10, 22);
    set_key(40, 42);
    run_stream(1'b0);
    check("R4 rise px8",  got_a[8],  100);
    check("R4 rise px9",  got_a[9],  300);
    check("R4 rise px10", got_a[10], 500);
    check("R4 rise px11", got_a[11], 700);
    check("R3 full px15", got_a[15], 800);
    check("R5 fall px20", got_a[20], 700);
    check("R5 fall px21", got_a[21], 500);
    check("R5 fall px22", got_a[22], 300);
    check("R5 fall px23", got_a[23], 100);
    check("R5 low px24",  got_a[24], 0);
    check("R7 reverse px38", got_a[38], 100);
    check("R7 reverse px39", got_a[39], 300);
    check("R7 reverse px40", got_a[40], 100);
    check("R7 reverse px41", got_a[41], 0);

    do_reset();
    run_stream(1'b1);
    check("R6 adv rise px3",  got_a[3],  100);
    check("R6 adv rise px4",  got_a[4],  300);
    check("R6 adv rise px5",  got_a[5],  500);
    check("R6 adv rise px6",  got_a[6],  700);
    check("R6 adv fall px15", got_a[15], 700);
    check("R6 adv fall px18", got_a[18], 100);

    do_reset();
    fill_rand();
    run_stream(1'b0);
    do_reset();
    fill_rand();
    run_stream(1'b1);

    // rounding: key stays high to the end so reset has to clear it
    do_reset();
    fill_const(1023, 0);
    set_key(10, LEN);
    run_stream(1'b0);
    check("R8 round px8", got_a[8], 895);
    check("R8 round px9", got_a[9], 639);

    do_reset();
    fill_const(1023, 1023);
    set_key(10, 22);
    run_stream(1'b0);
    check("R8 limit px9",  got_a[9],  1023);
    check("R8 limit px21", got_a[21], 1023);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule